// File: doc/BRIEF.md
# Tone Steering and Output Latch Controller

This block sits behind a dual-tone frequency decoder. The decoder supplies a raw "tone present" flag and a 4-bit key code on every clock. The block decides when a tone counts as a real key press and when a silence counts as the end of one. Both decisions use digital qualification counters whose lengths are set in clock cycles. A tone that survives its present window has its code captured into an output register. A short settling interval follows, and then a level data-valid output rises. At that same moment an active-low one-shot goes low for a fixed number of milliseconds. A silence that survives the absent window drops data-valid. The captured code stays on the data outputs until the next accepted tone replaces it.

An early steering flag follows the raw tone flag one cycle later whenever detection is enabled, so a host can see a tone coming before it is qualified. The data outputs come with a drive-enable output that follows the output-enable input, so a pad ring can tristate the bus. A power-down input clears every output and all internal state. When power-down is released, or after reset, detection stays disabled for a power-up interval. The one-shot width and the power-up interval are counted in milliseconds by prescalers from the system clock.

Control is a single state machine. Its states are WAKE (power-up interval running), IDLE (no tone), QUAL (tone present, present window counting), SETTLE (code captured, setup interval counting), VALID (accepted, tone still present) and RELEASE (tone gone, absent window counting). Its transitions are as follows:
- WAKE to IDLE: the power-up timer expires.
- IDLE to QUAL: the tone flag is seen high.
- QUAL to IDLE: the tone drops early.
- QUAL to SETTLE: the present window completes, and the code is captured.
- SETTLE to VALID: the setup interval ends, and the one-shot fires.
- VALID to RELEASE: the tone drops.
- RELEASE to VALID: the tone returns early.
- RELEASE to IDLE: the absent window completes.
- Any state to WAKE: power-down is asserted.

Top module: `tone_steer_ctrl`

## Requirements
- R1: `est_o` equals the `tone_det` value sampled at the previous rising edge when the state machine was outside WAKE and `pwr_dn` was low; otherwise it is 0.
- R2: A tone counts as accepted only if `tone_det` is sampled high on PRES_CYC+1 consecutive edges while the block is idle. A shorter run changes neither `dv_o` nor `dig_o`.
- R3: `dig_o` takes the code sampled on the last edge of the qualifying run. `dv_o` rises SETUP_CYC edges later, and `dig_o` is already stable when `dv_o` rises.
- R4: `dv_o` falls only after `tone_det` is sampled low on ABS_CYC+1 consecutive edges. A shorter gap keeps `dv_o` high and fires no new one-shot.
- R5: After `dv_o` falls, `dig_o` keeps the last captured code until a new tone is accepted.
- R6: `dvb_n_o` rests at 1 and goes to 0 on the edge where `dv_o` rises. It stays 0 for PULSE_MS*CLK_PER_MS cycles.
- R7: `dig_drv_o` is 1 exactly when `out_en` is 1. `out_en` has no effect on `dig_o` or on any other output.
- R8: While `pwr_dn` is 1, every edge forces `est_o`=0, `dv_o`=0, `dvb_n_o`=1 and `dig_o`=0, and the state machine returns to WAKE.
- R9: After reset or after `pwr_dn` falls, `tone_det` is ignored during the first PWRUP_MS*CLK_PER_MS+1 edges.
- R10: `dig_o` carries the 4-bit code from `tone_code` unchanged, bit 3 most significant (for example 4'b1001 or 4'b1101).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Active-high power-down, clears and halts the block |
| tone_det | input | 1 | Raw tone-present flag from the frequency decoder |
| tone_code | input | 4 | Key code from the frequency decoder |
| out_en | input | 1 | Output enable for the data bus |
| est_o | output | 1 | Early steering flag |
| dv_o | output | 1 | Level data-valid |
| dvb_n_o | output | 1 | Active-low one-shot data-valid |
| dig_o | output | 4 | Latched key code |
| dig_drv_o | output | 1 | Drive enable for the data pads (0 means high impedance) |

## Verification
The bench builds the block with CLK_PER_MS=20, PRES_CYC=12, ABS_CYC=8, SETUP_CYC=3, PULSE_MS=10 and PWRUP_MS=30. With these values the power-up interval is 600 cycles and the one-shot is 200 cycles, so both run to completion many times within a short run. The qualification windows are short enough that tones and gaps exactly one sample short of the threshold can be driven next to ones that just reach it. A one-shot can also end while a tone is still held, which lets a short gap show that no second pulse is fired.

// File: rtl/steer_pkg.sv
package steer_pkg;

    typedef enum logic [2:0] {
        ST_WAKE    = 3'd0,
        ST_IDLE    = 3'd1,
        ST_QUAL    = 3'd2,
        ST_SETTLE  = 3'd3,
        ST_VALID   = 3'd4,
        ST_RELEASE = 3'd5
    } steer_st_e;

endpackage

// File: rtl/steer_ms_timer.sv
// Millisecond interval timer with its own prescaler; busy for exactly
// CLK_PER_MS*MS cycles after the edge that starts it.
module steer_ms_timer #(
    parameter int CLK_PER_MS = 3580,
    parameter int MS         = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic busy_o
);
    localparam int SUB_W = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
    localparam int MS_W  = $clog2(MS + 1);
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CLK_PER_MS - 1);
    localparam logic [MS_W-1:0]  MS_LAST  = MS_W'(MS - 1);

    logic [SUB_W-1:0] sub_q;
    logic [MS_W-1:0]  ms_q;
    logic             busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_q  <= '0;
            ms_q   <= '0;
            busy_q <= 1'b0;
        end else if (clr) begin
            sub_q  <= '0;
            ms_q   <= '0;
            busy_q <= 1'b0;
        end else if (start) begin
            sub_q  <= '0;
            ms_q   <= '0;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                if (ms_q == MS_LAST) begin
                    busy_q <= 1'b0;
                end else begin
                    ms_q <= ms_q + 1'b1;
                end
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign busy_o = busy_q;

endmodule

// File: rtl/steer_code_latch.sv
// Holds the accepted key code and drives the pad enable.
module steer_code_latch #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              capture,
    input  logic [CODE_W-1:0] code_in,
    input  logic              out_en,
    output logic [CODE_W-1:0] code_o,
    output logic              drv_o
);
    logic [CODE_W-1:0] code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (clr) begin
            code_q <= '0;
        end else if (capture) begin
            code_q <= code_in;
        end
    end

    assign code_o = code_q;
    assign drv_o  = out_en;

endmodule

// File: rtl/steer_fsm.sv
// Steering state machine: qualifies presence and absence of the tone.
module steer_fsm
    import steer_pkg::*;
#(
    parameter int PRES_CYC  = 57280,
    parameter int ABS_CYC   = 28640,
    parameter int SETUP_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_dn,
    input  logic tone_det,
    input  logic wake_busy,
    output logic wake_start_o,
    output logic capture_o,
    output logic accept_o,
    output logic est_o,
    output logic dv_o
);
    localparam int MAX_CYC = (PRES_CYC > ABS_CYC)
                           ? ((PRES_CYC > SETUP_CYC) ? PRES_CYC : SETUP_CYC)
                           : ((ABS_CYC > SETUP_CYC) ? ABS_CYC : SETUP_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PRES_LAST  = CNT_W'(PRES_CYC - 1);
    localparam logic [CNT_W-1:0] ABS_LAST   = CNT_W'(ABS_CYC - 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);

    steer_st_e        st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic             arm_q;
    logic             est_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_WAKE;
            cnt_q <= '0;
            arm_q <= 1'b1;
            est_q <= 1'b0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
            arm_q <= pwr_dn;
            est_q <= tone_det && (st_q != ST_WAKE) && !pwr_dn;
        end
    end

    // next state
    always_comb begin
        st_nx     = st_q;
        cnt_nx    = cnt_q;
        capture_o = 1'b0;
        accept_o  = 1'b0;
        if (pwr_dn) begin
            st_nx  = ST_WAKE;
            cnt_nx = '0;
        end else begin
            unique case (st_q)
                ST_WAKE: begin
                    if (!arm_q && !wake_busy) st_nx = ST_IDLE;
                end
                ST_IDLE: begin
                    if (tone_det) begin
                        st_nx  = ST_QUAL;
                        cnt_nx = '0;
                    end
                end
                ST_QUAL: begin
                    if (!tone_det) begin
                        st_nx = ST_IDLE;
                    end else if (cnt_q == PRES_LAST) begin
                        st_nx     = ST_SETTLE;
                        cnt_nx    = '0;
                        capture_o = 1'b1;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
                ST_SETTLE: begin
                    if (cnt_q == SETUP_LAST) begin
                        st_nx    = ST_VALID;
                        cnt_nx   = '0;
                        accept_o = 1'b1;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
                ST_VALID: begin
                    if (!tone_det) begin
                        st_nx  = ST_RELEASE;
                        cnt_nx = '0;
                    end
                end
                ST_RELEASE: begin
                    if (tone_det) begin
                        st_nx = ST_VALID;
                    end else if (cnt_q == ABS_LAST) begin
                        st_nx = ST_IDLE;
                    end else begin
                        cnt_nx = cnt_q + 1'b1;
                    end
                end
                default: st_nx = ST_WAKE;
            endcase
        end
    end

    // outputs
    always_comb begin
        wake_start_o = arm_q && !pwr_dn;
        est_o        = est_q;
        dv_o         = (st_q == ST_VALID) || (st_q == ST_RELEASE);
    end

endmodule

// File: rtl/tone_steer_ctrl.sv
module tone_steer_ctrl #(
    parameter int CLK_PER_MS = 3580,
    parameter int PRES_CYC   = 57280,
    parameter int ABS_CYC    = 28640,
    parameter int SETUP_CYC  = 16,
    parameter int PULSE_MS   = 10,
    parameter int PWRUP_MS   = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_dn,
    input  logic       tone_det,
    input  logic [3:0] tone_code,
    input  logic       out_en,
    output logic       est_o,
    output logic       dv_o,
    output logic       dvb_n_o,
    output logic [3:0] dig_o,
    output logic       dig_drv_o
);
    localparam int CODE_W = 4;

    logic wake_start, wake_busy, capture, accept, pulse_busy;

    steer_fsm #(
        .PRES_CYC (PRES_CYC),
        .ABS_CYC  (ABS_CYC),
        .SETUP_CYC(SETUP_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_dn      (pwr_dn),
        .tone_det    (tone_det),
        .wake_busy   (wake_busy),
        .wake_start_o(wake_start),
        .capture_o   (capture),
        .accept_o    (accept),
        .est_o       (est_o),
        .dv_o        (dv_o)
    );

    steer_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .MS(PWRUP_MS)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwr_dn),
        .start (wake_start),
        .busy_o(wake_busy)
    );

    steer_ms_timer #(.CLK_PER_MS(CLK_PER_MS), .MS(PULSE_MS)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pwr_dn),
        .start (accept),
        .busy_o(pulse_busy)
    );

    steer_code_latch #(.CODE_W(CODE_W)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (pwr_dn),
        .capture(capture),
        .code_in(tone_code),
        .out_en (out_en),
        .code_o (dig_o),
        .drv_o  (dig_drv_o)
    );

    assign dvb_n_o = !pulse_busy;

endmodule

// File: rtl/tone_steer_ctrl_chk.sv
module tone_steer_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_dn,
    input logic       tone_det,
    input logic       est_o,
    input logic       dv_o,
    input logic       dvb_n_o,
    input logic [3:0] dig_o
);
    // R8
    pd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!est_o && !dv_o && dvb_n_o && dig_o == 4'd0));

    // R3
    setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dv_o) |-> $stable(dig_o));

    // R6
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dv_o) |-> !dvb_n_o);

    // R5
    keep_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dv_o) && !$past(pwr_dn)) |-> $stable(dig_o));

    // R1
    est_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_det |=> !est_o);
endmodule

bind tone_steer_ctrl tone_steer_ctrl_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pwr_dn  (pwr_dn),
    .tone_det(tone_det),
    .est_o   (est_o),
    .dv_o    (dv_o),
    .dvb_n_o (dvb_n_o),
    .dig_o   (dig_o)
);

// File: tb/tb_tone_steer_ctrl.sv
module tb_tone_steer_ctrl;
    localparam int CLK_P    = 10;
    localparam int CPM      = 20;
    localparam int PRES     = 12;
    localparam int ABSN     = 8;
    localparam int SETUP    = 3;
    localparam int PULSE_MS = 10;
    localparam int PWRUP_MS = 30;
    localparam int PULSE_N  = PULSE_MS * CPM;
    localparam int WAKE_N   = PWRUP_MS * CPM;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       tone = 1'b0;
    logic [3:0] code = 4'd0;
    logic       out_en = 1'b1;
    logic       est, dv, dvb_n, drv;
    logic [3:0] dig;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    tone_steer_ctrl #(
        .CLK_PER_MS(CPM), .PRES_CYC(PRES), .ABS_CYC(ABSN),
        .SETUP_CYC(SETUP), .PULSE_MS(PULSE_MS), .PWRUP_MS(PWRUP_MS)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .tone_det(tone),
        .tone_code(code), .out_en(out_en), .est_o(est), .dv_o(dv),
        .dvb_n_o(dvb_n), .dig_o(dig), .dig_drv_o(drv)
    );

    always #(CLK_P/2) clk = ~clk;

    // behavioural reference: phase 0 waking, 1 quiet, 2 qualifying,
    // 3 settling, 4 valid, 5 releasing
    int m_phase, m_wake, m_run, m_pulse;
    bit m_est;
    logic [3:0] m_dig;

    always @(posedge clk) begin
        if (!rst_n || pwr_dn) begin
            m_phase = 0; m_wake = WAKE_N + 1; m_run = 0;
            m_pulse = 0; m_est = 0; m_dig = 4'd0;
        end else begin
            m_est = tone && (m_phase != 0);
            if (m_pulse > 0) m_pulse--;
            case (m_phase)
                0: if (m_wake == 0) m_phase = 1; else m_wake--;
                1: if (tone) begin m_phase = 2; m_run = 0; end
                2: if (!tone) m_phase = 1;
                   else if (m_run == PRES - 1) begin m_phase = 3; m_run = 0; m_dig = code; end
                   else m_run++;
                3: if (m_run == SETUP - 1) begin m_phase = 4; m_pulse = PULSE_N; end
                   else m_run++;
                4: if (!tone) begin m_phase = 5; m_run = 0; end
                5: if (tone) m_phase = 4;
                   else if (m_run == ABSN - 1) m_phase = 1;
                   else m_run++;
                default: m_phase = 0;
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // per-cycle comparison, a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_P/4);
        if (rst_n && !done) begin
            chk("R1 est", est, m_est);
            chk("R3 dv", dv, (m_phase == 4 || m_phase == 5) ? 1 : 0);
            chk("R6 dvb_n", dvb_n, (m_pulse == 0) ? 1 : 0);
            chk("R5 dig", dig, m_dig);
            chk("R7 drv", drv, out_en);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<=60000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic hold(input bit t, input logic [3:0] c, input int n);
        @(negedge clk);
        tone = t; code = c;
        repeat (n - 1) @(negedge clk);
    endtask

    initial begin
        tone = 1'b1; code = 4'd7;
        repeat (3) @(negedge clk);
        chk("R8 reset dv", dv, 0);
        chk("R8 reset dvb_n", dvb_n, 1);
        chk("R8 reset dig", dig, 0);
        rst_n = 1'b1;
        // R9: tone held through the power-up interval is ignored
        repeat (WAKE_N - 5) @(negedge clk);
        chk("R9 est during wake", est, 0);
        chk("R9 dv during wake", dv, 0);
        hold(0, 4'd0, 40);
        // R2: one sample short of acceptance
        hold(1, 4'd5, PRES);
        hold(0, 4'd5, 30);
        chk("R2 short tone dv", dv, 0);
        chk("R2 short tone dig", dig, 0);
        // R10: accepted code 4'b1001
        hold(1, 4'd9, 260);
        chk("R10 code 1001", dig, 9);
        chk("R3 dv high", dv, 1);
        chk("R6 pulse over", dvb_n, 1);
        // R4: short gap keeps dv, no new one-shot
        hold(0, 4'd9, ABSN);
        hold(1, 4'd9, 20);
        chk("R4 dv held over gap", dv, 1);
        chk("R4 no new pulse", dvb_n, 1);
        // R5: long gap releases, code kept
        hold(0, 4'd2, ABSN + 10);
        chk("R4 dv released", dv, 0);
        chk("R5 code kept", dig, 9);
        // R7: output enable only moves the drive
        @(negedge clk); out_en = 1'b0;
        @(posedge clk); #(CLK_P/4);
        chk("R7 drive off", drv, 0);
        chk("R7 dig unaffected", dig, 9);
        hold(1, 4'd13, PRES + SETUP + 4);
        chk("R10 code 1101", dig, 13);
        chk("R6 pulse active", dvb_n, 0);
        @(negedge clk); out_en = 1'b1;
        // R8: power-down mid pulse
        @(negedge clk); pwr_dn = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 pd est", est, 0);
        chk("R8 pd dv", dv, 0);
        chk("R8 pd dvb_n", dvb_n, 1);
        chk("R8 pd dig", dig, 0);
        pwr_dn = 1'b0;
        repeat (WAKE_N - 5) @(negedge clk);
        chk("R9 wake after pd", dv, 0);
        repeat (40) @(negedge clk);
        chk("R10 accepted after wake", dig, 13);
        hold(0, 4'd0, 30);
        hold(1, 4'd0, PRES + 1);
        hold(0, 4'd0, SETUP + 5);
        chk("R10 code 0000", dig, 0);
        chk("R3 dv after min tone", dv, 1);
        repeat (PULSE_N) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule